// File: doc/BRIEF.md
# IN Endpoint Zero-Length Packet Inserter

This block sits beside an IN endpoint that is fed by automatic DMA and decides when a trailing zero-byte packet must follow the data. A transfer whose last chunk fills the maximum packet size exactly would otherwise look unfinished to the host. The host needs a short packet to end it, so the block arms an empty packet. That packet is answered on the next IN token after the final full packet has gone out. The endpoint request flag toward the processor stays low until the host has taken the empty packet.

Arming needs all of the following at the moment the final chunk is written: the automatic DMA mode is on, the zero-length enable is on, the request interrupt enable is on, the chunk size equals the maximum packet size, and the DMA remaining-unit count has reached zero. A final chunk that is shorter raises the request flag as soon as its packet has been sent. When automatic DMA is off, every served IN token raises the request flag. The block also keeps the DATA0/DATA1 toggle, so the empty packet carries the toggle that follows the last full packet. The packet engine that forms and sends packets is outside this block.

Top module: `zlp_inserter`

## Requirements
- R1: After reset, `send_zlp`, `req_flag` and `data_tgl` are all 0.
- R2: With `auto_dma_en` = 0, `chunk_wr` has no effect. Every `in_done` pulse sets `req_flag` in the next cycle.
- R3: With `auto_dma_en` = 1, a chunk written while `units_zero` = 0 is an intermediate packet. Its `in_done` leaves `req_flag` at 0 and `send_zlp` at 0.
- R4: A final chunk (`chunk_wr` with `auto_dma_en` = 1 and `units_zero` = 1) arms the empty packet only if `zlp_en` = 1, `req_irq_en` = 1 and `wr_bytes` equals `max_pkt`. The write alone changes neither output.
- R5: When armed, the `in_done` of the full final packet sets `send_zlp` to 1 in the next cycle and leaves `req_flag` at 0.
- R6: An `in_done` while `send_zlp` = 1 and `zlp_en` = 1 clears `send_zlp` and sets `req_flag` in the next cycle.
- R7: A final chunk that is not armed sets `req_flag` in the cycle after its `in_done`, and `send_zlp` stays 0.
- R8: Clearing `zlp_en` while `send_zlp` = 1 cancels the empty packet. In the next cycle `send_zlp` = 0 and `req_flag` = 1, and `data_tgl` is unchanged.
- R9: Clearing `zlp_en` after arming but before the full packet is sent means no empty packet is sent. `req_flag` is set in the cycle after that packet's `in_done`.
- R10: `data_tgl` (0 = DATA0, 1 = DATA1) inverts in the cycle after every `in_done` and is otherwise stable. As a result the empty packet uses the toggle that follows the last full packet.
- R11: `req_clr` clears `req_flag` in the next cycle. If a new request event happens in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_dma_en | input | 1 | Automatic DMA mode enable |
| zlp_en | input | 1 | Zero-length packet insertion enable |
| req_irq_en | input | 1 | Request interrupt enable |
| max_pkt | input | CNT_W | Maximum packet size in bytes |
| chunk_wr | input | 1 | One-cycle strobe: DMA finished writing a chunk to the send buffer |
| wr_bytes | input | CNT_W | Byte count of the chunk written with `chunk_wr` |
| units_zero | input | 1 | DMA remaining-unit count is zero after this write |
| in_done | input | 1 | One-cycle strobe: host IN token served and acknowledged |
| req_clr | input | 1 | Clear the request flag |
| send_zlp | output | 1 | Answer the next IN token with a zero-byte DATA packet |
| req_flag | output | 1 | Endpoint request flag |
| data_tgl | output | 1 | Data toggle for the next packet (0 = DATA0, 1 = DATA1) |

## Verification
A wrong arming decision shows up one cycle after the full packet's `in_done`. At that point `send_zlp` stays 0 when it should rise, or rises when a request should have been raised. A sequencer stuck in a pending state either keeps `send_zlp` high past the next IN token or never raises `req_flag`, and both are visible on the next served token or the next change of `zlp_en`. A lost toggle update appears on `data_tgl` one cycle after any `in_done`, so each packet of the sweep exposes it at once.

// File: rtl/zlp_pkg.sv
package zlp_pkg;

    typedef enum logic [1:0] {
        ZS_IDLE   = 2'd0,
        ZS_SHORT  = 2'd1,
        ZS_FULL   = 2'd2,
        ZS_ZLP    = 2'd3
    } zlp_state_e;

    typedef struct packed {
        logic final_wr;
        logic arm;
    } wr_eval_t;

    typedef struct packed {
        logic fire;
        logic zlp;
    } seq_out_t;

    function automatic logic size_fills(input logic [15:0] bytes, input logic [15:0] maxp);
        return bytes == maxp;
    endfunction

endpackage

// File: rtl/zlp_arm_eval.sv
module zlp_arm_eval
    import zlp_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             auto_dma_en,
    input  logic             zlp_en,
    input  logic             req_irq_en,
    input  logic [CNT_W-1:0] max_pkt,
    input  logic             chunk_wr,
    input  logic [CNT_W-1:0] wr_bytes,
    input  logic             units_zero,
    output wr_eval_t         ev
);
    localparam int PADW = 16 - CNT_W;

    logic fills;

    always_comb begin
        fills       = size_fills({{PADW{1'b0}}, wr_bytes}, {{PADW{1'b0}}, max_pkt});
        ev.final_wr = chunk_wr & auto_dma_en & units_zero;
        ev.arm      = ev.final_wr & zlp_en & req_irq_en & fills;
    end

endmodule

// File: rtl/zlp_seq.sv
module zlp_seq
    import zlp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     auto_dma_en,
    input  logic     zlp_en,
    input  logic     in_done,
    input  wr_eval_t ev,
    output seq_out_t so
);
    zlp_state_e st, st_nx;
    logic       fire;

    always_comb begin
        st_nx = st;
        fire  = 1'b0;
        unique case (st)
            ZS_IDLE: begin
                if (ev.final_wr) begin
                    st_nx = ev.arm ? ZS_FULL : ZS_SHORT;
                end else if (in_done && !auto_dma_en) begin
                    fire = 1'b1;
                end
            end
            ZS_SHORT: begin
                if (in_done) begin
                    st_nx = ZS_IDLE;
                    fire  = 1'b1;
                end
            end
            ZS_FULL: begin
                if (in_done) begin
                    if (zlp_en && auto_dma_en) begin
                        st_nx = ZS_ZLP;
                    end else begin
                        st_nx = ZS_IDLE;
                        fire  = 1'b1;
                    end
                end else if (!zlp_en) begin
                    st_nx = ZS_SHORT;
                end
            end
            ZS_ZLP: begin
                if (!zlp_en || in_done) begin
                    st_nx = ZS_IDLE;
                    fire  = 1'b1;
                end
            end
            default: st_nx = ZS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ZS_IDLE;
        else     st <= st_nx;
    end

    always_comb begin
        so.fire = fire;
        so.zlp  = (st == ZS_ZLP);
    end

endmodule

// File: rtl/zlp_req_tgl.sv
module zlp_req_tgl (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic req_clr,
    input  logic in_done,
    output logic req_flag,
    output logic data_tgl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_flag <= 1'b0;
            data_tgl <= 1'b0;
        end else begin
            req_flag <= fire | (req_flag & ~req_clr);
            if (in_done) data_tgl <= ~data_tgl;
        end
    end

endmodule

// File: rtl/zlp_inserter.sv
module zlp_inserter
    import zlp_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_dma_en,
    input  logic             zlp_en,
    input  logic             req_irq_en,
    input  logic [CNT_W-1:0] max_pkt,
    input  logic             chunk_wr,
    input  logic [CNT_W-1:0] wr_bytes,
    input  logic             units_zero,
    input  logic             in_done,
    input  logic             req_clr,
    output logic             send_zlp,
    output logic             req_flag,
    output logic             data_tgl
);
    wr_eval_t ev;
    seq_out_t so;

    zlp_arm_eval #(.CNT_W(CNT_W)) u_eval (
        .auto_dma_en (auto_dma_en),
        .zlp_en      (zlp_en),
        .req_irq_en  (req_irq_en),
        .max_pkt     (max_pkt),
        .chunk_wr    (chunk_wr),
        .wr_bytes    (wr_bytes),
        .units_zero  (units_zero),
        .ev          (ev)
    );

    zlp_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .auto_dma_en (auto_dma_en),
        .zlp_en      (zlp_en),
        .in_done     (in_done),
        .ev          (ev),
        .so          (so)
    );

    zlp_req_tgl u_rt (
        .clk      (clk),
        .rst      (rst),
        .fire     (so.fire),
        .req_clr  (req_clr),
        .in_done  (in_done),
        .req_flag (req_flag),
        .data_tgl (data_tgl)
    );

    assign send_zlp = so.zlp;

endmodule

// File: rtl/zlp_inserter_chk.sv
module zlp_inserter_chk (
    input logic clk,
    input logic rst,
    input logic auto_dma_en,
    input logic zlp_en,
    input logic in_done,
    input logic req_clr,
    input logic send_zlp,
    input logic req_flag,
    input logic data_tgl
);
    AST_ZLP_FROM_TOKEN: assert property (@(posedge clk) disable iff (rst)
        $rose(send_zlp) |-> $past(in_done)); // R5

    AST_ZLP_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (send_zlp && zlp_en && in_done) |=> (!send_zlp && req_flag)); // R6

    AST_ZLP_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (send_zlp && !zlp_en) |=> (!send_zlp && req_flag)); // R8

    AST_PLAIN_REQ: assert property (@(posedge clk) disable iff (rst)
        (!auto_dma_en && in_done) |=> req_flag); // R2

    AST_TGL_FLIP: assert property (@(posedge clk) disable iff (rst)
        in_done |=> (data_tgl != $past(data_tgl))); // R10

    AST_TGL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_done |=> $stable(data_tgl)); // R10

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_flag && !req_clr) |=> req_flag); // R11

    AST_REQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (req_clr && !in_done && !(send_zlp && !zlp_en)) |=> !req_flag); // R11

endmodule

bind zlp_inserter zlp_inserter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .auto_dma_en (auto_dma_en),
    .zlp_en      (zlp_en),
    .in_done     (in_done),
    .req_clr     (req_clr),
    .send_zlp    (send_zlp),
    .req_flag    (req_flag),
    .data_tgl    (data_tgl)
);

// File: tb/zlp_inserter_bench.sv
`timescale 1ns/1ps
module zlp_inserter_bench;
    localparam int CNT_W = 11;
    localparam int MAXP  = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             auto_dma_en = 1'b0;
    logic             zlp_en = 1'b0;
    logic             req_irq_en = 1'b0;
    logic [CNT_W-1:0] max_pkt = CNT_W'(MAXP);
    logic             chunk_wr = 1'b0;
    logic [CNT_W-1:0] wr_bytes = '0;
    logic             units_zero = 1'b0;
    logic             in_done = 1'b0;
    logic             req_clr = 1'b0;
    logic             send_zlp, req_flag, data_tgl;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;
    logic exp_t = 1'b0;

    always #2.5 clk = ~clk;

    zlp_inserter #(.CNT_W(CNT_W)) u_zlp_inserter (
        .clk(clk), .rst(rst), .auto_dma_en(auto_dma_en), .zlp_en(zlp_en),
        .req_irq_en(req_irq_en), .max_pkt(max_pkt), .chunk_wr(chunk_wr),
        .wr_bytes(wr_bytes), .units_zero(units_zero), .in_done(in_done),
        .req_clr(req_clr), .send_zlp(send_zlp), .req_flag(req_flag),
        .data_tgl(data_tgl)
    );

    task automatic check(input string tag, input logic ez, input logic er);
        total++;
        if (send_zlp !== ez || req_flag !== er || data_tgl !== exp_t) begin
            bad++;
            $display("FAIL %s: actual zlp=%b req=%b tgl=%b expected zlp=%b req=%b tgl=%b",
                     tag, send_zlp, req_flag, data_tgl, ez, er, exp_t);
        end
    endtask

    task automatic pulse_wr(input int b);
        @(negedge clk);
        wr_bytes = CNT_W'(b);
        chunk_wr = 1'b1;
        @(negedge clk);
        chunk_wr = 1'b0;
    endtask

    task automatic pulse_in();
        @(negedge clk);
        in_done = 1'b1;
        @(negedge clk);
        in_done = 1'b0;
        exp_t = ~exp_t;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        req_clr = 1'b1;
        @(negedge clk);
        req_clr = 1'b0;
    endtask

    task automatic scenario(input bit a, input bit z, input bit i, input bit u, input int b);
        bit armed;
        armed = a && z && i && u && (b == MAXP);
        @(negedge clk);
        auto_dma_en = a; zlp_en = z; req_irq_en = i; units_zero = u;
        pulse_wr(b);
        check("R4 write alone changes no output", 1'b0, 1'b0);
        pulse_in();
        if (!a)          check("R2 plain mode in_done sets request", 1'b0, 1'b1);
        else if (!u)     check("R3 intermediate packet no request", 1'b0, 1'b0);
        else if (armed)  check("R5 full final packet arms zero-length", 1'b1, 1'b0);
        else             check("R7 short final packet sets request", 1'b0, 1'b1);
        if (armed) begin
            pulse_in();
            check("R6 zero-length taken sets request (R10 toggle)", 1'b0, 1'b1);
        end
        pulse_clr();
        check("R11 clear drops request", 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", 1'b0, 1'b0);

        for (int a = 0; a < 2; a++)
            for (int z = 0; z < 2; z++)
                for (int i = 0; i < 2; i++)
                    for (int u = 0; u < 2; u++)
                        for (int b = 1; b <= MAXP; b++)
                            scenario(a[0], z[0], i[0], u[0], b);

        // R8: cancel while pending
        @(negedge clk);
        auto_dma_en = 1'b1; zlp_en = 1'b1; req_irq_en = 1'b1; units_zero = 1'b1;
        pulse_wr(MAXP);
        pulse_in();
        check("R8 pending before cancel", 1'b1, 1'b0);
        zlp_en = 1'b0;
        @(negedge clk);
        check("R8 cancel drops zero-length and sets request", 1'b0, 1'b1);
        pulse_clr();
        check("R11 clear after cancel", 1'b0, 1'b0);

        // R9: disable after arming, before the full packet is sent
        zlp_en = 1'b1;
        pulse_wr(MAXP);
        zlp_en = 1'b0;
        @(negedge clk);
        check("R9 no output before packet sent", 1'b0, 1'b0);
        pulse_in();
        check("R9 request after full packet, no zero-length", 1'b0, 1'b1);
        pulse_clr();

        // R11: set wins over clear in the same cycle
        auto_dma_en = 1'b0;
        @(negedge clk);
        in_done = 1'b1; req_clr = 1'b1;
        @(negedge clk);
        in_done = 1'b0; req_clr = 1'b0;
        exp_t = ~exp_t;
        check("R11 set wins over simultaneous clear", 1'b0, 1'b1);

        // R10: multi-packet toggle run in auto mode with intermediate chunks
        pulse_clr();
        auto_dma_en = 1'b1; zlp_en = 1'b1; req_irq_en = 1'b1; units_zero = 1'b0;
        for (int k = 0; k < 3; k++) begin
            pulse_wr(MAXP);
            pulse_in();
            check("R10 toggle on intermediate packet (R3)", 1'b0, 1'b0);
        end
        units_zero = 1'b1;
        pulse_wr(MAXP);
        pulse_in();
        check("R10 toggle on final full packet (R5)", 1'b1, 1'b0);
        pulse_in();
        check("R10 zero-length uses next toggle (R6)", 1'b0, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule